// File: doc/BRIEF.md
# Dual-CPU Bridge Control Register File

This block is the register file that sits between a PC-side host processor and a 68000-side processor sharing one machine. The host reaches eight byte-wide registers through a small I/O port (offsets 0 to 7). The 68K reaches the same eight registers through its own port, along with three registers of its own: a mailbox byte, a bank select for a 1 MiB view of host memory, and a two-word unlock register. The file holds the ROM page select, the base of the host's memory window and its enables, the mailbox bits that cross between the CPUs, the run/reset handoff control, a status byte, and a detector that latches an "unlocked" flag when a magic word pair is written.

The outputs drive the 68K reset, the host hold, the video source select and the mapping controls. These are combinational decodes of the stored state and change in the cycle after the write that causes them. Reads on either port are combinational. A host-side bus timeout input sets a sticky flag, and any read of the status offset clears it. Address decoding, the data path and the ROM lie outside this block.

Top module: `xcpu_bridge_regs`

## Requirements
- R1: After reset the host offsets 0..7 read 00, FF, CE, 00, 80, status, 00, 00. m68_reset is 1, host_hold is 0, video_md is 0 and win_base is CE000h.
- R2: Offset 0 is an 8-bit page select that both ports can write, and it drives rom_page. Offset 1 always reads FFh, and writes to it have no effect.
- R3: Offset 2 reads as {110, w[3:0], 0}, where only written bits 4:1 are stored. win_base equals the offset 2 value shifted left by 12.
- R4: Offset 3 bit 0 drives aux_rom_en. host_win_en is 1 only when offset 3 bits 0 and 1 are both set.
- R5: Offset 3 bits 5:4 read mailbox bits 1:0 as last written by the 68K, and host writes to them are ignored. Host-written offset 3 bits 7:6 read as mailbox (68K address 8) bits 3:2.
- R6: When the host writes 1 to offset 4 bit 0, host_hold goes to 1 and m68_reset goes to 0. A host write of 0 to that bit leaves it set. A 68K write of 0 clears it, which gives m68_reset=1 and host_hold=0.
- R7: When offset 4 bits 3 and 1 are both set, bit 0 is ignored and both m68_reset and host_hold are 0. Moving between 68K-only mode and this dual mode never raises m68_reset.
- R8: Offset 4 bit 2 drives video_md (1 = MD video). Offset 4 bit 7 resets to 1. A 68K write of 0 clears it, and host writes never change it.
- R9: Offset 5 is read-only and reads {00, unlocked, 0, timeout, sw_video_rgb, 0, sw_pc_boot}. A bus_timeout pulse sets the timeout bit, and a read of offset 5 from either port clears it.
- R10: unlocked sets only after a word-wide write of 5345h to 68K address 10, followed directly by a word-wide write of 4741h to address 11. Byte writes never unlock. Once set, the flag holds until reset.
- R11: Offsets 6 and 7 form m68_win_page = {off7[3:0], off6[7:1], 0}. Offset 6 bit 0 reads 0 and offset 7 bits 7:4 read 0.
- R12: 68K address 9 is an 8-bit bank register that drives pc_bank. cart_at_zero is offset 4 bit 1. pc_mem_at_zero is mailbox bit 7 while offset 4 bit 1 is clear.
- R13: When both ports write the same shared register in the same cycle, the 68K value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (clears the timeout when reading offset 5) |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| m68_we | input | 1 | 68K write strobe |
| m68_re | input | 1 | 68K read strobe |
| m68_word | input | 1 | 68K write is word-wide |
| m68_addr | input | 4 | 68K address: 0-7 shared, 8 mailbox, 9 bank, 10/11 unlock words |
| m68_wdata | input | 16 | 68K write data (byte registers use bits 7:0) |
| m68_rdata | output | 8 | 68K read data (combinational) |
| bus_timeout | input | 1 | Pulse when a host access to the 68K bus times out |
| sw_pc_boot | input | 1 | Boot switch level (1 = PC boot) |
| sw_video_rgb | input | 1 | Video switch level (1 = RGB) |
| m68_reset | output | 1 | Holds the 68K in reset |
| host_hold | output | 1 | Pauses the host CPU |
| video_md | output | 1 | Video source select, 1 = MD |
| rom_page | output | 8 | ROM page select |
| aux_rom_en | output | 1 | Auxiliary ROM enable |
| host_win_en | output | 1 | Host window into 68K space enable |
| win_base | output | 20 | Host window base address |
| m68_win_page | output | 12 | 68K page for host window access |
| pc_bank | output | 8 | 1 MiB host bank seen by the 68K |
| cart_at_zero | output | 1 | Cartridge mapped at 68K address 0 |
| pc_mem_at_zero | output | 1 | Host memory mapped at 68K address 0 |

## Verification
A wrong value in any stored bit shows up in the cycle after the write that caused it, either at the matching read port or at the mapping outputs. Nothing is pipelined, so there are no delayed symptoms. The handoff state is the costly one to get wrong: a lost or spurious run bit appears at once as a CPU that is held or released when it should not be, and the dual-mode transitions are observed directly on m68_reset. An unlock sequence recognised incorrectly, or a timeout flag that stays set, is visible on the next read of offset 5.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int DW        = 8;
  localparam int WIN_SHIFT = 12;
  localparam int NSHARED   = 8;
  localparam int MW        = 16;
  localparam logic [MW-1:0] MAGIC_FIRST  = 16'h5345;
  localparam logic [MW-1:0] MAGIC_SECOND = 16'h4741;
  localparam logic [DW-1:0] OWN_MASK     = 8'hCF;
  localparam logic [3:0]    WIN_RST      = 4'b0111;
  localparam logic [DW-1:0] CTL_RST      = 8'h80;

  function automatic logic [DW-1:0] winreg_view(input logic [3:0] w);
    return {3'b110, w, 1'b0};
  endfunction

  function automatic logic [DW+WIN_SHIFT-1:0] win_base_of(input logic [DW-1:0] r);
    return {r, {WIN_SHIFT{1'b0}}};
  endfunction

  function automatic logic [DW-1:0] ctl_from_host(input logic [DW-1:0] cur, input logic [DW-1:0] wd);
    return {cur[7], wd[6:1], cur[0] | wd[0]};
  endfunction

  function automatic logic [DW-1:0] ctl_from_m68(input logic [DW-1:0] cur, input logic [DW-1:0] wd);
    return {cur[7] & wd[7], wd[6:1], cur[0] & wd[0]};
  endfunction
endpackage

// File: rtl/xb_shared_regs.sv
module xb_shared_regs
  import xb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSHARED-1:0] h_wsel,
  input  logic [NSHARED-1:0] m_wsel,
  input  logic [DW-1:0]      h_wd,
  input  logic [DW-1:0]      m_wd,
  input  logic               bus_timeout,
  input  logic               stat_clr,
  output logic [DW-1:0]      page_q,
  output logic [3:0]         win_q,
  output logic [DW-1:0]      ctl3_q,
  output logic [DW-1:0]      ctl4_q,
  output logic [6:0]         pg_lo_q,
  output logic [3:0]         pg_hi_q,
  output logic               tout_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      win_q   <= WIN_RST;
      ctl3_q  <= '0;
      ctl4_q  <= CTL_RST;
      pg_lo_q <= '0;
      pg_hi_q <= '0;
      tout_q  <= 1'b0;
    end else begin
      if (m_wsel[0])      page_q <= m_wd;
      else if (h_wsel[0]) page_q <= h_wd;

      if (m_wsel[2])      win_q <= m_wd[4:1];
      else if (h_wsel[2]) win_q <= h_wd[4:1];

      if (m_wsel[3])      ctl3_q <= m_wd & OWN_MASK;
      else if (h_wsel[3]) ctl3_q <= h_wd & OWN_MASK;

      if (m_wsel[4])      ctl4_q <= ctl_from_m68(ctl4_q, m_wd);
      else if (h_wsel[4]) ctl4_q <= ctl_from_host(ctl4_q, h_wd);

      if (m_wsel[6])      pg_lo_q <= m_wd[7:1];
      else if (h_wsel[6]) pg_lo_q <= h_wd[7:1];

      if (m_wsel[7])      pg_hi_q <= m_wd[3:0];
      else if (h_wsel[7]) pg_hi_q <= h_wd[3:0];

      if (bus_timeout)    tout_q <= 1'b1;
      else if (stat_clr)  tout_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xb_m68_regs.sv
module xb_m68_regs
  import xb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mbox_we,
  input  logic          bank_we,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] mbox_q,
  output logic [DW-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbox_q <= '0;
      bank_q <= '0;
    end else begin
      if (mbox_we) mbox_q <= wd & OWN_MASK;
      if (bank_we) bank_q <= wd;
    end
  end
endmodule

// File: rtl/xb_unlock_det.sv
module xb_unlock_det
  import xb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_first,
  input  logic          we_second,
  input  logic          word,
  input  logic [MW-1:0] wd,
  output logic          armed,
  output logic          unlocked
);
  logic hit_first, hit_second;
  assign hit_first  = we_first  && word && (wd == MAGIC_FIRST);
  assign hit_second = we_second && word && (wd == MAGIC_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (we_first)       armed <= hit_first;
      else if (we_second) armed <= 1'b0;
      if (armed && hit_second) unlocked <= 1'b1;
    end
  end
endmodule

// File: rtl/xb_handoff.sv
module xb_handoff
  import xb_pkg::*;
(
  input  logic [DW-1:0] ctl,
  output logic          dual,
  output logic          m68_reset,
  output logic          host_hold
);
  assign dual      = ctl[3] & ctl[1];
  assign m68_reset = ~dual & ~ctl[0];
  assign host_hold = ~dual &  ctl[0];
endmodule

// File: rtl/xcpu_bridge_regs.sv
module xcpu_bridge_regs
  import xb_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_we,
  input  logic         host_re,
  input  logic [2:0]   host_addr,
  input  logic [7:0]   host_wdata,
  output logic [7:0]   host_rdata,
  input  logic         m68_we,
  input  logic         m68_re,
  input  logic         m68_word,
  input  logic [3:0]   m68_addr,
  input  logic [15:0]  m68_wdata,
  output logic [7:0]   m68_rdata,
  input  logic         bus_timeout,
  input  logic         sw_pc_boot,
  input  logic         sw_video_rgb,
  output logic         m68_reset,
  output logic         host_hold,
  output logic         video_md,
  output logic [7:0]   rom_page,
  output logic         aux_rom_en,
  output logic         host_win_en,
  output logic [19:0]  win_base,
  output logic [11:0]  m68_win_page,
  output logic [7:0]   pc_bank,
  output logic         cart_at_zero,
  output logic         pc_mem_at_zero
);
  localparam logic [3:0] A_MBOX = 4'd8;
  localparam logic [3:0] A_BANK = 4'd9;
  localparam logic [3:0] A_UNLO = 4'd10;
  localparam logic [3:0] A_UNHI = 4'd11;

  logic [NSHARED-1:0] h_wsel, m_wsel;
  logic [DW-1:0] page_q, ctl3_q, ctl4_q, mbox_q, bank_q;
  logic [3:0]    win_q, pg_hi_q;
  logic [6:0]    pg_lo_q;
  logic          tout_q, stat_clr, unlocked, armed, dual;
  logic          ctl_run, m68_run_clr;
  logic [DW-1:0] view [NSHARED];

  for (genvar i = 0; i < NSHARED; i++) begin : g_sel
    assign h_wsel[i] = host_we && (host_addr == i);
    assign m_wsel[i] = m68_we && !m68_addr[3] && (m68_addr[2:0] == i);
  end

  assign stat_clr = (host_re && host_addr == 3'd5) ||
                    (m68_re && m68_addr == 4'd5);

  xb_shared_regs u_shared (
    .clk(clk), .rst_n(rst_n), .h_wsel(h_wsel), .m_wsel(m_wsel),
    .h_wd(host_wdata), .m_wd(m68_wdata[7:0]), .bus_timeout(bus_timeout),
    .stat_clr(stat_clr), .page_q(page_q), .win_q(win_q), .ctl3_q(ctl3_q),
    .ctl4_q(ctl4_q), .pg_lo_q(pg_lo_q), .pg_hi_q(pg_hi_q), .tout_q(tout_q)
  );

  xb_m68_regs u_m68 (
    .clk(clk), .rst_n(rst_n),
    .mbox_we(m68_we && m68_addr == A_MBOX),
    .bank_we(m68_we && m68_addr == A_BANK),
    .wd(m68_wdata[7:0]), .mbox_q(mbox_q), .bank_q(bank_q)
  );

  xb_unlock_det u_unlock (
    .clk(clk), .rst_n(rst_n),
    .we_first(m68_we && m68_addr == A_UNLO),
    .we_second(m68_we && m68_addr == A_UNHI),
    .word(m68_word), .wd(m68_wdata), .armed(armed), .unlocked(unlocked)
  );

  xb_handoff u_handoff (
    .ctl(ctl4_q), .dual(dual), .m68_reset(m68_reset), .host_hold(host_hold)
  );

  assign ctl_run     = ctl4_q[0];
  assign m68_run_clr = m_wsel[4] && !m68_wdata[0];

  always_comb begin
    view[0] = page_q;
    view[1] = '1;
    view[2] = winreg_view(win_q);
    view[3] = ctl3_q | {2'b00, mbox_q[1:0], 4'b0000};
    view[4] = ctl4_q;
    view[5] = {2'b00, unlocked, 1'b0, tout_q, sw_video_rgb, 1'b0, sw_pc_boot};
    view[6] = {pg_lo_q, 1'b0};
    view[7] = {4'b0000, pg_hi_q};
  end

  assign host_rdata = view[host_addr];

  always_comb begin
    if (!m68_addr[3])           m68_rdata = view[m68_addr[2:0]];
    else if (m68_addr == A_MBOX) m68_rdata = mbox_q | {4'b0000, ctl3_q[7:6], 2'b00};
    else if (m68_addr == A_BANK) m68_rdata = bank_q;
    else                         m68_rdata = '0;
  end

  assign video_md       = ctl4_q[2];
  assign rom_page       = page_q;
  assign aux_rom_en     = ctl3_q[0];
  assign host_win_en    = ctl3_q[0] & ctl3_q[1];
  assign win_base       = win_base_of(view[2]);
  assign m68_win_page   = {pg_hi_q, pg_lo_q, 1'b0};
  assign pc_bank        = bank_q;
  assign cart_at_zero   = ctl4_q[1];
  assign pc_mem_at_zero = mbox_q[7] & ~ctl4_q[1];
endmodule

// File: rtl/xb_checker.sv
module xb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [2:0]  host_addr,
  input logic        m68_we,
  input logic        m68_word,
  input logic [3:0]  m68_addr,
  input logic [15:0] m68_wdata,
  input logic [7:0]  rom_page,
  input logic        m68_reset,
  input logic        host_hold,
  input logic        aux_rom_en,
  input logic        host_win_en,
  input logic        bus_timeout,
  input logic        stat_clr,
  input logic        tout_q,
  input logic        unlocked,
  input logic        ctl_run,
  input logic        m68_run_clr
);
  a_r6_not_both_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    host_hold |-> !m68_reset);

  a_r7_no_reset_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    (!m68_reset && ctl_run && !m68_run_clr) |=> !m68_reset);

  a_r13_m68_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 3'd0 && m68_we && m68_addr == 4'd0)
      |=> rom_page == $past(m68_wdata[7:0]));

  a_r10_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  a_r10_byte_never_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (m68_we && !m68_word && !unlocked) |=> !unlocked);

  a_r9_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timeout |=> tout_q);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !bus_timeout) |=> !tout_q);

  a_r4_window_needs_rom: assert property (@(posedge clk) disable iff (!rst_n)
    host_win_en |-> aux_rom_en);
endmodule

bind xcpu_bridge_regs xb_checker chk_i (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .m68_we(m68_we), .m68_word(m68_word), .m68_addr(m68_addr),
  .m68_wdata(m68_wdata), .rom_page(rom_page), .m68_reset(m68_reset),
  .host_hold(host_hold), .aux_rom_en(aux_rom_en), .host_win_en(host_win_en),
  .bus_timeout(bus_timeout), .stat_clr(stat_clr), .tout_q(tout_q),
  .unlocked(unlocked), .ctl_run(ctl_run), .m68_run_clr(m68_run_clr)
);

// File: tb/xcpu_bridge_regs_tb_top.sv
module xcpu_bridge_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic host_we = 0, host_re = 0, m68_we = 0, m68_re = 0, m68_word = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata, m68_rdata, rom_page, pc_bank;
  logic [3:0] m68_addr = 0;
  logic [15:0] m68_wdata = 0;
  logic bus_timeout = 0, sw_pc_boot = 1, sw_video_rgb = 0;
  logic m68_reset, host_hold, video_md, aux_rom_en, host_win_en;
  logic cart_at_zero, pc_mem_at_zero;
  logic [19:0] win_base;
  logic [11:0] m68_win_page;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xcpu_bridge_regs dut_i (.*);

  // {wr_is_68k, waddr[3:0], wdata[7:0], rd_is_68k, raddr[3:0], expected[7:0]}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 4'd0, 8'hA5, 1'b0, 4'd0, 8'hA5},  // R2
    {1'b1, 4'd0, 8'h3C, 1'b0, 4'd0, 8'h3C},  // R2
    {1'b0, 4'd1, 8'h00, 1'b0, 4'd1, 8'hFF},  // R2
    {1'b0, 4'd2, 8'hFF, 1'b0, 4'd2, 8'hDE},  // R3
    {1'b0, 4'd2, 8'h00, 1'b0, 4'd2, 8'hC0},  // R3
    {1'b0, 4'd6, 8'hFF, 1'b0, 4'd6, 8'hFE},  // R11
    {1'b0, 4'd7, 8'hFF, 1'b0, 4'd7, 8'h0F},  // R11
    {1'b0, 4'd3, 8'hF3, 1'b1, 4'd8, 8'h0C},  // R5
    {1'b1, 4'd8, 8'hF3, 1'b0, 4'd3, 8'hF3},  // R5
    {1'b1, 4'd9, 8'h5A, 1'b1, 4'd9, 8'h5A},  // R12
    {1'b0, 4'd4, 8'h04, 1'b0, 4'd4, 8'h84},  // R8
    {1'b1, 4'd4, 8'h04, 1'b0, 4'd4, 8'h04},  // R8
    {1'b0, 4'd4, 8'h80, 1'b0, 4'd4, 8'h00}   // R8
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk); host_we = 0;
  endtask

  task automatic mw(input logic [3:0] a, input logic [15:0] d, input logic word);
    @(negedge clk); m68_addr = a; m68_wdata = d; m68_word = word; m68_we = 1;
    @(negedge clk); m68_we = 0; m68_word = 0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_re = 1; #1 d = host_rdata;
    @(negedge clk); host_re = 0;
  endtask

  task automatic mr(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); m68_addr = a; m68_re = 1; #1 d = m68_rdata;
    @(negedge clk); m68_re = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] rst_exp [8] = '{8'h00, 8'hFF, 8'hCE, 8'h00, 8'h80, 8'h01, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 m68_reset", m68_reset, 1);
    chk("R1 host_hold", host_hold, 0);
    chk("R1 video_md", video_md, 0);
    chk("R1 win_base", win_base, 20'hCE000);
    for (int i = 0; i < 8; i++) begin
      hr(i[2:0], d);
      chk($sformatf("R1 offset %0d", i), d, rst_exp[i]);
    end
    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) mw(VEC[i][24:21], {8'h00, VEC[i][20:13]}, 1'b0);
      else            hw(VEC[i][23:21], VEC[i][20:13]);
      if (VEC[i][12]) mr(VEC[i][11:8], d);
      else            hr(VEC[i][10:8], d);
      chk($sformatf("R2-table vector %0d", i), d, VEC[i][7:0]);
    end
    chk("R3 win_base", win_base, 20'hC0000);
    chk("R11 m68_win_page", m68_win_page, 12'hFFE);
    chk("R12 pc_bank", pc_bank, 8'h5A);
    chk("R12 pc_mem_at_zero", pc_mem_at_zero, 1);
    hw(4, 8'h02);
    chk("R12 cart_at_zero", cart_at_zero, 1);
    chk("R12 pc_mem_at_zero masked", pc_mem_at_zero, 0);
    hw(4, 8'h00);
    // R4
    chk("R4 window enabled", host_win_en, 1);
    hw(3, 8'h01);
    chk("R4 rom only", {aux_rom_en, host_win_en}, 2'b10);
    hw(3, 8'h02);
    chk("R4 window bit alone", {aux_rom_en, host_win_en}, 2'b00);
    // R8 video
    hw(4, 8'h04);
    chk("R8 video_md set", video_md, 1);
    hw(4, 8'h00);
    chk("R8 video_md clear", video_md, 0);
    // R6 handoff
    hw(4, 8'h01);
    chk("R6 handoff", {m68_reset, host_hold}, 2'b01);
    hw(4, 8'h00);
    hr(4, d);
    chk("R6 host cannot clear run", d, 8'h01);
    chk("R6 still held", {m68_reset, host_hold}, 2'b01);
    // R7 dual mode
    hw(4, 8'h0B);
    chk("R7 dual from 68k-only", {m68_reset, host_hold}, 2'b00);
    hw(4, 8'h01);
    chk("R7 back to 68k-only", {m68_reset, host_hold}, 2'b01);
    mw(4, 16'h0000, 1'b0);
    chk("R6 68k clears run", {m68_reset, host_hold}, 2'b10);
    hw(4, 8'h0A);
    chk("R7 run ignored in dual", {m68_reset, host_hold}, 2'b00);
    hw(4, 8'h00);
    chk("R7 leave dual", {m68_reset, host_hold}, 2'b10);
    // R13 same-cycle priority
    @(negedge clk);
    host_addr = 0; host_wdata = 8'h11; host_we = 1;
    m68_addr = 0; m68_wdata = 16'h0022; m68_we = 1;
    @(negedge clk); host_we = 0; m68_we = 0;
    chk("R13 68k wins", rom_page, 8'h22);
    // R9 timeout
    @(negedge clk); bus_timeout = 1; @(negedge clk); bus_timeout = 0;
    hr(5, d);
    chk("R9 timeout set", d, 8'h09);
    hr(5, d);
    chk("R9 timeout cleared by read", d, 8'h01);
    // R10 unlock
    mw(10, 16'h5345, 1'b0);
    mw(11, 16'h4741, 1'b1);
    hr(5, d);
    chk("R10 byte first word rejected", d, 8'h01);
    mw(11, 16'h4741, 1'b1);
    hr(5, d);
    chk("R10 second word alone rejected", d, 8'h01);
    mw(10, 16'h5345, 1'b1);
    mw(11, 16'h4741, 1'b1);
    hr(5, d);
    chk("R10 unlocked", d, 8'h21);
    mw(10, 16'h0000, 1'b0);
    hr(5, d);
    chk("R10 unlock sticky", d, 8'h21);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule